// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block takes interrupt events from on-chip sources, packs each into a sixteen-byte vector of four 32-bit words, and writes the vector into a circular buffer in external memory through a simple write-request port. A byte-granular write pointer advances by sixteen for each vector. Host software drains the ring and reports how far it has read, either through a register write or through a doorbell write that carries the new read pointer. A level interrupt output tells the host that vectors are waiting.

A write that lands on the oldest unread entry still goes ahead. It also sets a sticky overflow flag in the top bit of the readable write-pointer word. Software clears that flag by writing a one to a clear bit in the control register, and it resynchronises by resuming sixteen bytes past the reported write pointer. The block can also copy the write-pointer word to a programmed memory address after each vector.

The write engine is a state machine with six states. `S_IDLE` waits for an event. `S_VEC0`, `S_VEC1`, `S_VEC2` and `S_VEC3` each issue one vector word and wait for its acknowledge. `S_WBACK` issues the write-pointer copy. The transitions are:
- accept: `S_IDLE` to `S_VEC0` when an event is taken.
- word step: `S_VEC0` to `S_VEC1` to `S_VEC2` to `S_VEC3`, each on an acknowledge.
- finish: `S_VEC3` to `S_IDLE`, on acknowledge with writeback off.
- copy: `S_VEC3` to `S_WBACK`, on acknowledge with writeback on.
- copy done: `S_WBACK` to `S_IDLE`, on acknowledge.

Top module: `irq_ring_producer`

## Requirements
- R1: After reset, the write pointer (offset 3) and read pointer (offset 2) read 0, `irq_o`, `busy_o`, `evt_ready` and `mem_req` are low, and the ring size field reads 2.
- R2: `evt_ready` is high only in `S_IDLE` with both ring enable (CTRL bit 0) and interrupt enable (CTRL bit 1) set. `irq_o` is low whenever either of those bits is clear, even if an interrupt is pending.
- R3: An accepted event produces four writes, in order, to ring base + write pointer + 0, 4, 8 and 12. The ring base is the BASE register (offset 1) shifted left by 8 into a 40-bit address. The words are: word 0 = {24'b0, source id}, word 1 = {4'b0, 28-bit source data}, word 2 = {16-bit address-space id, 8-bit VM id, 8-bit ring id}, and word 3 = 0.
- R4: While `mem_req` is high and `mem_ack` is low, the request, address and data hold steady into the next cycle.
- R5: Each vector advances the write pointer by 16 modulo the ring size. The ring holds 4 << s bytes, where s is CTRL bits 12:8 clamped to the range 2 to MAX_LOG2. The pointer is otherwise unchanged except by a register load.
- R6: When the advanced write pointer equals the read pointer, the vector is still written and bit 31 of the write-pointer word is set. The bit stays set until CTRL is written with bit 4 equal to one.
- R7: With writeback on (CTRL bit 2), each vector is followed by exactly one write of the new write-pointer word, overflow bit included. The target address is {WBHI bits 7:0, WBLO bits 31:2, 2'b00}, with WBLO at offset 4 and WBHI at offset 5. With writeback off, exactly four writes occur.
- R8: With the doorbell path disabled, a write to offset 2 sets the read pointer to the written value ANDed with the ring mask, with its low four bits cleared.
- R9: With the doorbell path enabled (offset 6, bit 0), register writes to offset 2 are ignored. A doorbell whose offset equals offset 6 bits 25:16 loads the read pointer from `db_data`. Doorbells with another offset, or while the path is disabled, are ignored.
- R10: Each written vector sets the pending flag. A read-pointer update clears it, unless rearm (CTRL bit 3) is set and the ring is non-empty after the update.
- R11: `busy_o` is high while a memory write sequence is in progress, or while the write and read pointers differ.
- R12: A write to offset 3 loads the write pointer with the value ANDed with the ring mask, with its low four bits cleared. The overflow bit is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event taken when high with evt_valid |
| evt_src_id | input | 8 | Source identifier |
| evt_src_data | input | 28 | Source-specific data |
| evt_ring_id | input | 8 | Ring identifier |
| evt_vm_id | input | 8 | Virtual machine identifier |
| evt_pasid | input | 16 | Process address-space identifier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| db_valid | input | 1 | Doorbell write strobe |
| db_offset | input | DBO_W | Doorbell offset |
| db_data | input | 32 | Doorbell payload (read pointer) |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 40 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write accepted |
| irq_o | output | 1 | Level interrupt |
| busy_o | output | 1 | Write in progress or ring non-empty |

## Verification
Directed vectors in a 64-byte ring fill the ring from an empty start. The fourth vector lands on the read pointer, which separates a correct overflow rule from one that fires one slot early or never. Read-pointer updates are tried with rearm on and off against a non-empty ring, which tells the rearm rule apart from a plain clear. Doorbells with matching and non-matching offsets are mixed with blocked register writes. Random phases vary the event fields, the base, the ring size, the writeback setting, the acknowledge latency and the moments of draining, and so expose address, wrap and field-packing errors that fixed values could mask.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_VEC0,
        S_VEC1,
        S_VEC2,
        S_VEC3,
        S_WBACK
    } wr_state_e;

    typedef struct packed {
        logic [15:0] pasid;
        logic [7:0]  vm_id;
        logic [7:0]  ring_id;
        logic [27:0] src_data;
        logic [7:0]  src_id;
    } ivec_t;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_BASE = 3'd1;
    localparam logic [2:0] A_RPTR = 3'd2;
    localparam logic [2:0] A_WPTR = 3'd3;
    localparam logic [2:0] A_WBLO = 3'd4;
    localparam logic [2:0] A_WBHI = 3'd5;
    localparam logic [2:0] A_DBEL = 3'd6;

    localparam int C_RING  = 0;
    localparam int C_IRQ   = 1;
    localparam int C_WB    = 2;
    localparam int C_REARM = 3;
    localparam int C_OCLR  = 4;
    localparam int C_SZLO  = 8;
    localparam int DB_OFLO = 16;

endpackage

// File: rtl/irq_ring_cfg.sv
module irq_ring_cfg
    import irq_ring_pkg::*;
#(
    parameter int MAX_LOG2 = 14,
    parameter int PTR_W    = 16,
    parameter int DBO_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             db_valid,
    input  logic [DBO_W-1:0] db_offset,
    input  logic [31:0]      db_data,
    input  logic [31:0]      wptr_word,
    output logic             ring_on,
    output logic             irq_on,
    output logic             wb_on,
    output logic             rearm_on,
    output logic             ovf_clr,
    output logic [PTR_W-1:0] ptr_mask,
    output logic [39:0]      ring_base,
    output logic [39:0]      wb_addr,
    output logic [PTR_W-1:0] rptr,
    output logic             rptr_upd,
    output logic [PTR_W-1:0] rptr_nxt,
    output logic             wptr_ld,
    output logic [PTR_W-1:0] wptr_ld_val
);

    localparam logic [4:0] SZ_MIN = 5'd2;
    localparam logic [4:0] SZ_MAX = 5'(MAX_LOG2);

    logic             ring_q, irq_q, wb_q, rearm_q, db_on_q;
    logic [4:0]       sz_q, sz_eff;
    logic [31:0]      base_q, wblo_q;
    logic [7:0]       wbhi_q;
    logic [DBO_W-1:0] db_off_q;
    logic [PTR_W-1:0] rptr_q, aln_mask;
    logic             wr_ctrl, wr_rptr_reg, db_hit;
    logic             unused_db;

    assign unused_db = ^db_data[31:PTR_W];

    always_comb begin
        if (sz_q < SZ_MIN)      sz_eff = SZ_MIN;
        else if (sz_q > SZ_MAX) sz_eff = SZ_MAX;
        else                    sz_eff = sz_q;
    end

    assign ptr_mask  = (PTR_W'(4) << sz_eff) - PTR_W'(1);
    assign aln_mask  = ptr_mask & ~PTR_W'(15);

    assign wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
    assign wr_rptr_reg = reg_wr && (reg_addr == A_RPTR) && !db_on_q;
    assign db_hit      = db_valid && db_on_q && (db_offset == db_off_q);

    assign rptr_upd    = wr_rptr_reg || db_hit;
    assign rptr_nxt    = db_on_q ? (db_data[PTR_W-1:0] & aln_mask)
                                 : (reg_wdata[PTR_W-1:0] & aln_mask);
    assign wptr_ld     = reg_wr && (reg_addr == A_WPTR);
    assign wptr_ld_val = reg_wdata[PTR_W-1:0] & aln_mask;
    assign ovf_clr     = wr_ctrl && reg_wdata[C_OCLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q   <= 1'b0;
            irq_q    <= 1'b0;
            wb_q     <= 1'b0;
            rearm_q  <= 1'b0;
            sz_q     <= SZ_MIN;
            base_q   <= '0;
            wblo_q   <= '0;
            wbhi_q   <= '0;
            db_on_q  <= 1'b0;
            db_off_q <= '0;
            rptr_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ring_q  <= reg_wdata[C_RING];
                irq_q   <= reg_wdata[C_IRQ];
                wb_q    <= reg_wdata[C_WB];
                rearm_q <= reg_wdata[C_REARM];
                sz_q    <= reg_wdata[C_SZLO +: 5];
            end
            if (reg_wr && reg_addr == A_BASE) base_q <= reg_wdata;
            if (reg_wr && reg_addr == A_WBLO) wblo_q <= reg_wdata;
            if (reg_wr && reg_addr == A_WBHI) wbhi_q <= reg_wdata[7:0];
            if (reg_wr && reg_addr == A_DBEL) begin
                db_on_q  <= reg_wdata[0];
                db_off_q <= reg_wdata[DB_OFLO +: DBO_W];
            end
            if (rptr_upd) rptr_q <= rptr_nxt;
        end
    end

    assign ring_on   = ring_q;
    assign irq_on    = irq_q;
    assign wb_on     = wb_q;
    assign rearm_on  = rearm_q;
    assign rptr      = rptr_q;
    assign ring_base = {base_q, 8'h00};
    assign wb_addr   = {wbhi_q, wblo_q[31:2], 2'b00};

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[C_RING]     = ring_q;
                reg_rdata[C_IRQ]      = irq_q;
                reg_rdata[C_WB]       = wb_q;
                reg_rdata[C_REARM]    = rearm_q;
                reg_rdata[C_SZLO +: 5] = sz_q;
            end
            A_BASE: reg_rdata = base_q;
            A_RPTR: reg_rdata[PTR_W-1:0] = rptr_q;
            A_WPTR: reg_rdata = wptr_word;
            A_WBLO: reg_rdata = wblo_q;
            A_WBHI: reg_rdata[7:0] = wbhi_q;
            A_DBEL: begin
                reg_rdata[0]                = db_on_q;
                reg_rdata[DB_OFLO +: DBO_W] = db_off_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R8
    rptr_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_RPTR && !db_on_q && !db_valid)
        |=> (rptr_q == $past(reg_wdata[PTR_W-1:0] & aln_mask)));

    // R9
    rptr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_on_q && !db_valid) |=> $stable(rptr_q));

endmodule

// File: rtl/irq_ring_ptr.sv
module irq_ring_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             wr_active,
    input  logic [PTR_W-1:0] ptr_mask,
    input  logic [PTR_W-1:0] rptr,
    input  logic             rptr_upd,
    input  logic [PTR_W-1:0] rptr_nxt,
    input  logic             wptr_ld,
    input  logic [PTR_W-1:0] wptr_ld_val,
    input  logic             ovf_clr,
    input  logic             rearm_on,
    output logic [31:0]      wptr_word,
    output logic [31:0]      commit_word,
    output logic             pend,
    output logic             busy
);

    logic [PTR_W-1:0] wptr_q, adv, wptr_nxt;
    logic             ovf_q, ovf_nxt, hit, pend_q;

    assign adv = (wptr_q + PTR_W'(16)) & ptr_mask;
    assign hit = commit && (adv == rptr);

    always_comb begin
        wptr_nxt = wptr_q;
        if (wptr_ld)     wptr_nxt = wptr_ld_val;
        else if (commit) wptr_nxt = adv;
        ovf_nxt = hit || (ovf_q && !ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            ovf_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            wptr_q <= wptr_nxt;
            ovf_q  <= ovf_nxt;
            if (commit)        pend_q <= 1'b1;
            else if (rptr_upd) pend_q <= rearm_on && (rptr_nxt != wptr_q);
        end
    end

    always_comb begin
        wptr_word              = '0;
        wptr_word[PTR_W-1:0]   = wptr_q;
        wptr_word[31]          = ovf_q;
        commit_word            = '0;
        commit_word[PTR_W-1:0] = adv;
        commit_word[31]        = ovf_nxt;
    end

    assign pend = pend_q;
    assign busy = wr_active || (wptr_q != rptr);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R5
    wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !wptr_ld) |=> $stable(wptr_q));

    // R10
    pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_upd && !commit && !rearm_on) |=> !pend_q);

endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
    import irq_ring_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  ivec_t            evt_vec,
    input  logic             accept_en,
    output logic             evt_ready,
    input  logic [39:0]      ring_base,
    input  logic [PTR_W-1:0] wptr,
    input  logic             wb_on,
    input  logic [39:0]      wb_addr,
    input  logic [31:0]      commit_word,
    output logic             mem_req,
    output logic [39:0]      mem_addr,
    output logic [31:0]      mem_data,
    input  logic             mem_ack,
    output logic             commit,
    output logic             wr_active
);

    wr_state_e   state_q, state_d;
    ivec_t       vec_q;
    logic [39:0] slot_q, wba_q;
    logic [31:0] wbd_q;
    logic        take;

    assign take = evt_valid && evt_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take)    state_d = S_VEC0;
            S_VEC0:  if (mem_ack) state_d = S_VEC1;
            S_VEC1:  if (mem_ack) state_d = S_VEC2;
            S_VEC2:  if (mem_ack) state_d = S_VEC3;
            S_VEC3:  if (mem_ack) state_d = wb_on ? S_WBACK : S_IDLE;
            S_WBACK: if (mem_ack) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= '0;
            slot_q <= '0;
            wba_q  <= '0;
            wbd_q  <= '0;
        end else begin
            if (take) begin
                vec_q  <= evt_vec;
                slot_q <= ring_base + {{(40-PTR_W){1'b0}}, wptr};
            end
            if (commit) begin
                wba_q <= wb_addr;
                wbd_q <= commit_word;
            end
        end
    end

    always_comb begin
        evt_ready = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = '0;
        mem_data  = '0;
        commit    = 1'b0;
        unique case (state_q)
            S_IDLE: evt_ready = accept_en;
            S_VEC0: begin
                mem_req  = 1'b1;
                mem_addr = slot_q;
                mem_data = {24'h0, vec_q.src_id};
            end
            S_VEC1: begin
                mem_req  = 1'b1;
                mem_addr = slot_q + 40'd4;
                mem_data = {4'h0, vec_q.src_data};
            end
            S_VEC2: begin
                mem_req  = 1'b1;
                mem_addr = slot_q + 40'd8;
                mem_data = {vec_q.pasid, vec_q.vm_id, vec_q.ring_id};
            end
            S_VEC3: begin
                mem_req  = 1'b1;
                mem_addr = slot_q + 40'd12;
                mem_data = '0;
                commit   = mem_ack;
            end
            S_WBACK: begin
                mem_req  = 1'b1;
                mem_addr = wba_q;
                mem_data = wbd_q;
            end
            default: ;
        endcase
    end

    assign wr_active = (state_q != S_IDLE);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    // R3
    accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (mem_req && mem_addr == $past(ring_base + {{(40-PTR_W){1'b0}}, wptr})));

endmodule

// File: rtl/irq_ring_producer.sv
module irq_ring_producer
    import irq_ring_pkg::*;
#(
    parameter int MAX_LOG2 = 14,
    parameter int DBO_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic [7:0]       evt_src_id,
    input  logic [27:0]      evt_src_data,
    input  logic [7:0]       evt_ring_id,
    input  logic [7:0]       evt_vm_id,
    input  logic [15:0]      evt_pasid,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             db_valid,
    input  logic [DBO_W-1:0] db_offset,
    input  logic [31:0]      db_data,
    output logic             mem_req,
    output logic [39:0]      mem_addr,
    output logic [31:0]      mem_data,
    input  logic             mem_ack,
    output logic             irq_o,
    output logic             busy_o
);

    localparam int PTR_W = MAX_LOG2 + 2;

    logic             ring_on, irq_on, wb_on, rearm_on, ovf_clr;
    logic [PTR_W-1:0] ptr_mask, rptr, rptr_nxt, wptr_ld_val;
    logic [39:0]      ring_base, wb_addr;
    logic             rptr_upd, wptr_ld, commit, wr_active, pend;
    logic [31:0]      wptr_word, commit_word;
    ivec_t            evt_vec;

    assign evt_vec = '{pasid: evt_pasid, vm_id: evt_vm_id, ring_id: evt_ring_id,
                       src_data: evt_src_data, src_id: evt_src_id};

    irq_ring_cfg #(.MAX_LOG2(MAX_LOG2), .PTR_W(PTR_W), .DBO_W(DBO_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .db_valid(db_valid), .db_offset(db_offset), .db_data(db_data),
        .wptr_word(wptr_word),
        .ring_on(ring_on), .irq_on(irq_on), .wb_on(wb_on), .rearm_on(rearm_on),
        .ovf_clr(ovf_clr), .ptr_mask(ptr_mask), .ring_base(ring_base), .wb_addr(wb_addr),
        .rptr(rptr), .rptr_upd(rptr_upd), .rptr_nxt(rptr_nxt),
        .wptr_ld(wptr_ld), .wptr_ld_val(wptr_ld_val)
    );

    irq_ring_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .wr_active(wr_active), .ptr_mask(ptr_mask),
        .rptr(rptr), .rptr_upd(rptr_upd), .rptr_nxt(rptr_nxt),
        .wptr_ld(wptr_ld), .wptr_ld_val(wptr_ld_val),
        .ovf_clr(ovf_clr), .rearm_on(rearm_on),
        .wptr_word(wptr_word), .commit_word(commit_word),
        .pend(pend), .busy(busy_o)
    );

    irq_ring_writer #(.PTR_W(PTR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_vec(evt_vec), .accept_en(ring_on && irq_on),
        .evt_ready(evt_ready),
        .ring_base(ring_base), .wptr(wptr_word[PTR_W-1:0]),
        .wb_on(wb_on), .wb_addr(wb_addr), .commit_word(commit_word),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .commit(commit), .wr_active(wr_active)
    );

    assign irq_o = ring_on && irq_on && pend;

    // R2
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ready |-> (!mem_req && ring_on && irq_on));

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy_o);

endmodule

// File: tb/irq_ring_producer_bench.sv
`timescale 1ns/1ps
module irq_ring_producer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [7:0]  evt_src_id = '0;
    logic [27:0] evt_src_data = '0;
    logic [7:0]  evt_ring_id = '0;
    logic [7:0]  evt_vm_id = '0;
    logic [15:0] evt_pasid = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        db_valid = 1'b0;
    logic [9:0]  db_offset = '0;
    logic [31:0] db_data = '0;
    logic        mem_req;
    logic [39:0] mem_addr;
    logic [31:0] mem_data;
    logic        mem_ack = 1'b0;
    logic        irq_o, busy_o;

    always #2 clk = ~clk;

    irq_ring_producer u_irq_ring_producer (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_src_id(evt_src_id), .evt_src_data(evt_src_data), .evt_ring_id(evt_ring_id),
        .evt_vm_id(evt_vm_id), .evt_pasid(evt_pasid),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .db_valid(db_valid), .db_offset(db_offset), .db_data(db_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
        .irq_o(irq_o), .busy_o(busy_o)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [39:0] cap_a[$];
    logic [31:0] cap_d[$];
    int dly = 0;

    // model state
    logic        m_ring = 0, m_irqen = 0, m_wb = 0, m_rearm = 0, m_db = 0;
    logic [4:0]  m_sz = 5'd2;
    logic [15:0] m_mask = 16'h000F;
    logic [39:0] m_base = '0, m_wba = '0;
    logic [15:0] m_wptr = '0, m_rptr = '0;
    logic        m_ovf = 0, m_pend = 0;

    always @(negedge clk) begin
        if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req) begin
            if (dly == 0) begin
                mem_ack <= 1'b1;
                cap_a.push_back(mem_addr);
                cap_d.push_back(mem_data);
                dly = int'($urandom % 3);
            end else dly = dly - 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_mask(input logic [4:0] s);
        int e;
        e = (s < 2) ? 2 : ((s > 14) ? 14 : int'(s));
        return 16'(((32'd4 << e) - 1));
    endfunction

    function automatic logic [31:0] f_wword();
        return {m_ovf, 15'h0, m_wptr};
    endfunction

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_ctrl(input logic clr);
        wreg(3'd0, {19'h0, m_sz, 3'h0, clr, m_rearm, m_wb, m_irqen, m_ring});
        m_mask = f_mask(m_sz);
        if (clr) m_ovf = 1'b0;
    endtask

    task automatic set_rptr_reg(input logic [31:0] v);
        wreg(3'd2, v);
        if (!m_db) begin
            m_rptr = v[15:0] & m_mask & 16'hFFF0;
            m_pend = m_rearm && (m_rptr != m_wptr);
        end
    endtask

    task automatic ring(input logic [9:0] off, input logic [31:0] v);
        @(negedge clk);
        db_valid = 1'b1; db_offset = off; db_data = v;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic send_ev(input string req);
        logic [7:0]  sid = 8'($urandom);
        logic [27:0] sdt = 28'($urandom);
        logic [7:0]  rid = 8'($urandom);
        logic [7:0]  vid = 8'($urandom);
        logic [15:0] pid = 16'($urandom);
        int n0 = cap_a.size();
        int need = m_wb ? 5 : 4;
        logic [39:0] slot;
        logic [31:0] ew [4];
        @(negedge clk);
        evt_src_id = sid; evt_src_data = sdt; evt_ring_id = rid; evt_vm_id = vid; evt_pasid = pid;
        evt_valid = 1'b1;
        while (!evt_ready) @(negedge clk);
        @(negedge clk);
        evt_valid = 1'b0;
        while (cap_a.size() < n0 + need) @(negedge clk);
        repeat (4) @(negedge clk);
        slot = m_base + {24'h0, m_wptr};
        if (((m_wptr + 16'd16) & m_mask) == m_rptr) m_ovf = 1'b1;
        m_wptr = (m_wptr + 16'd16) & m_mask;
        m_pend = 1'b1;
        ew[0] = {24'h0, sid};
        ew[1] = {4'h0, sdt};
        ew[2] = {pid, vid, rid};
        ew[3] = 32'h0;
        // R3 word addresses and contents
        for (int k = 0; k < 4; k++) begin
            chk({req, " R3 addr"}, 64'(cap_a[n0 + k]), 64'(slot + 40'(4 * k)));
            chk({req, " R3 data"}, 64'(cap_d[n0 + k]), 64'(ew[k]));
        end
        // R7 writeback count and word
        chk({req, " R7 count"}, 64'(cap_a.size()), 64'(n0 + need));
        if (m_wb) begin
            chk({req, " R7 wb addr"}, 64'(cap_a[n0 + 4]), 64'(m_wba));
            chk({req, " R7 wb data"}, 64'(cap_d[n0 + 4]), 64'(f_wword()));
        end
    endtask

    task automatic chk_ptrs(input string req);
        logic [31:0] d;
        rreg(3'd3, d);
        chk({req, " R5/R6 wptr word"}, 64'(d), 64'(f_wword()));
        rreg(3'd2, d);
        chk({req, " R8 rptr"}, 64'(d), 64'(m_rptr));
        chk({req, " R10 irq"}, 64'(irq_o), 64'(m_pend && m_ring && m_irqen));
        chk({req, " R11 busy"}, 64'(busy_o), 64'(m_wptr != m_rptr));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(3'd3, d); chk("R1 wptr", 64'(d), 64'h0);
        rreg(3'd2, d); chk("R1 rptr", 64'(d), 64'h0);
        rreg(3'd0, d); chk("R1 size field", 64'(d[12:8]), 64'd2);
        chk("R1 irq", 64'(irq_o), 64'h0);
        chk("R1 busy", 64'(busy_o), 64'h0);
        chk("R1 ready", 64'(evt_ready), 64'h0);
        chk("R1 req", 64'(mem_req), 64'h0);

        // R2 disabled ring takes nothing
        evt_valid = 1'b1;
        repeat (10) @(negedge clk);
        chk("R2 ready while off", 64'(evt_ready), 64'h0);
        chk("R2 no writes while off", 64'(cap_a.size()), 64'h0);
        evt_valid = 1'b0;
        m_ring = 1'b1;
        put_ctrl(1'b0);
        chk("R2 ready with irq enable clear", 64'(evt_ready), 64'h0);

        // configure: 64-byte ring, writeback on
        m_base = {32'h12345678, 8'h00};
        wreg(3'd1, 32'h12345678);
        wreg(3'd4, 32'h0000_1003);
        wreg(3'd5, 32'h0000_01AB);
        m_wba = 40'hAB_0000_1000;
        m_irqen = 1'b1; m_wb = 1'b1; m_sz = 5'd4;
        put_ctrl(1'b0);
        chk("R2 ready enabled", 64'(evt_ready), 64'h1);

        // fill the ring: fourth vector lands on rptr
        send_ev("fill1"); chk_ptrs("fill1");
        send_ev("fill2");
        send_ev("fill3"); chk_ptrs("fill3");
        send_ev("R6 wrap overflow"); chk_ptrs("R6 wrap overflow");
        chk("R6 overflow bit set", 64'(m_ovf), 64'h1);
        send_ev("R6 sticky"); chk_ptrs("R6 sticky");
        put_ctrl(1'b1);
        chk_ptrs("R6 cleared");

        // R10 drain clears interrupt
        set_rptr_reg(32'(m_wptr));
        chk_ptrs("R10 drain");
        chk("R10 irq low after drain", 64'(irq_o), 64'h0);

        // R10 rearm keeps interrupt with entries left
        m_rearm = 1'b1; put_ctrl(1'b0);
        send_ev("rearm a");
        send_ev("rearm b");
        set_rptr_reg(32'((m_rptr + 16'd16) & m_mask));
        chk_ptrs("R10 rearm");
        chk("R10 irq kept by rearm", 64'(irq_o), 64'h1);
        m_rearm = 1'b0; put_ctrl(1'b0);
        set_rptr_reg(32'(m_rptr));
        chk("R10 irq cleared without rearm", 64'(irq_o), 64'h0);
        chk("R11 busy with entries left", 64'(busy_o), 64'h1);

        // R12 write pointer load
        wreg(3'd3, 32'h0000_1234);
        m_wptr = 16'h1234 & m_mask & 16'hFFF0;
        chk_ptrs("R12 load");

        // R9 doorbell path
        wreg(3'd6, {6'h0, 10'h055, 15'h0, 1'b1});
        m_db = 1'b1;
        set_rptr_reg(32'h0);
        chk_ptrs("R9 reg write blocked");
        ring(10'h054, 32'h30);
        chk_ptrs("R9 wrong offset");
        ring(10'h055, 32'h30);
        m_rptr = 16'h30; m_pend = 1'b0;
        chk_ptrs("R9 matching doorbell");
        wreg(3'd6, 32'h0);
        m_db = 1'b0;
        ring(10'h055, 32'h10);
        chk_ptrs("R9 doorbell when off");

        // R8 masking
        set_rptr_reg(32'h0000_FFF7);
        chk_ptrs("R8 mask");

        // R7 writeback off gives four writes
        m_wb = 1'b0; put_ctrl(1'b0);
        send_ev("R7 no writeback"); chk_ptrs("R7 no writeback");

        // R2 interrupt gated by enables
        m_ring = 1'b0; put_ctrl(1'b0);
        chk("R2 irq gated", 64'(irq_o), 64'h0);
        chk("R2 ready gated", 64'(evt_ready), 64'h0);
        m_ring = 1'b1; put_ctrl(1'b0);
        chk("R2 irq restored", 64'(irq_o), 64'h1);

        // R5 size clamp via load readback
        m_sz = 5'd0; put_ctrl(1'b0);
        wreg(3'd3, 32'hFFFF_FFF0);
        m_wptr = 16'hFFF0 & m_mask & 16'hFFF0;
        rreg(3'd3, d); chk("R5 clamp low", 64'(d[15:0]), 64'h0);
        m_sz = 5'd31; put_ctrl(1'b0);
        wreg(3'd3, 32'hFFFF_FFF0);
        m_wptr = 16'hFFF0;
        rreg(3'd3, d); chk("R5 clamp high", 64'(d[15:0]), 64'hFFF0);

        // random phase
        for (int i = 0; i < 60; i++) begin
            if (i % 15 == 0) begin
                m_sz = 5'(3 + ($urandom % 3));
                m_wb = 1'($urandom);
                put_ctrl(1'b1);
                m_base = {32'($urandom), 8'h00};
                wreg(3'd1, m_base[39:8]);
                wreg(3'd3, 32'h0);
                m_wptr = 16'h0;
                set_rptr_reg(32'h0);
            end
            if ($urandom % 4 == 0) begin
                set_rptr_reg(32'(m_wptr));
                chk("R10 random drain irq", 64'(irq_o), 64'h0);
                chk("R11 random drain busy", 64'(busy_o), 64'h0);
            end
            if ($urandom % 8 == 0) begin
                m_wb = ~m_wb;
                put_ctrl(1'b0);
            end
            if (m_ovf && ($urandom % 2 == 0)) put_ctrl(1'b1);
            send_ev("R3 random");
            chk_ptrs("R5 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule